// File: doc/BRIEF.md
# Dual-Pool Physical Register Free List

This block holds the unused physical register tags for the rename stage of an out-of-order core. Integer and floating-point registers share one physical index space. Integer tags take the low range, starting at zero, and floating-point tags follow directly after the last integer tag. Each class has its own first-in first-out pool. Rename can take one integer tag and one floating-point tag in the same cycle, each through a valid/ready allocate port. The tag on offer is shown combinationally while ready is high.

Freed tags come back from commit or squash logic in two ways.

- **Generic return port.** It sorts each tag into a pool by its index. It drops the hardwired-zero register of each class, and it drops any index beyond the last floating-point register.
- **Dedicated return ports.** There is one per pool. Each pushes its tag into its pool without any filtering.

Each pool reports a not-empty flag and a live count. Two sticky flags record misuse: an allocate attempted on an empty pool, and a push that found its pool full.

Top module: `regfree_pools`

## Requirements
- R1: After reset, the integer pool holds tags INT_ARCH..INT_PHYS-1 in ascending order. The floating-point pool holds INT_PHYS+FP_ARCH..INT_PHYS+FP_PHYS-1 in ascending order. Both error flags are 0.
- R2: Each pool hands out tags in the order they entered it.
- R3: An allocate port's ready and the pool's not-empty flag are both 1 exactly when the pool's count is nonzero. While ready is 1 the port shows the oldest tag, and valid with ready removes that tag at the clock edge. While ready is 0 the tag output is 0.
- R4: Valid on an allocate port while its ready is 0 removes nothing and sets underflow_err one cycle later. underflow_err then stays 1 until reset.
- R5: A generic return with a tag below INT_PHYS enters the integer pool. A tag from INT_PHYS up to INT_PHYS+FP_PHYS-1 enters the floating-point pool.
- R6: The generic port drops tag ZERO_IDX, and it drops tag ZERO_IDX+INT_PHYS. Neither pool changes.
- R7: The generic port drops any tag of INT_PHYS+FP_PHYS or above. Neither pool changes.
- R8: The dedicated return ports push any tag value into their own pool, including the zero-register tags.
- R9: An allocate and a return to the same pool in one cycle both take effect, and the count is unchanged.
- R10: When the generic port and the dedicated port feed the same pool in one cycle, the generic tag is queued ahead of the dedicated tag.
- R11: A push that finds no free slot, counting a same-cycle allocate as freeing one, is dropped. It sets overflow_err one cycle later, and overflow_err stays 1 until reset. When only one slot is left, the generic tag takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ia_valid | input | 1 | Integer allocate request |
| ia_ready | output | 1 | Integer pool can grant |
| ia_tag | output | TAG_W | Integer tag on offer |
| fa_valid | input | 1 | Floating-point allocate request |
| fa_ready | output | 1 | Floating-point pool can grant |
| fa_tag | output | TAG_W | Floating-point tag on offer |
| gr_valid | input | 1 | Generic return strobe |
| gr_tag | input | TAG_W | Generic returned tag |
| ir_valid | input | 1 | Integer dedicated return strobe |
| ir_tag | input | TAG_W | Integer dedicated tag |
| fr_valid | input | 1 | Floating-point dedicated return strobe |
| fr_tag | input | TAG_W | Floating-point dedicated tag |
| int_nonempty | output | 1 | Integer pool has a tag |
| int_count | output | ICW | Integer free count |
| fp_nonempty | output | 1 | Floating-point pool has a tag |
| fp_count | output | FCW | Floating-point free count |
| underflow_err | output | 1 | Sticky empty-allocate flag |
| overflow_err | output | 1 | Sticky full-push flag |

## Verification
The offered tag and ready are combinational from pool state, so the bench reads them 1 ns after it drives the inputs, in the same cycle and before the edge. Counts, not-empty flags and both error flags change at the clock edge that takes the request. The bench therefore reads them 1 ns after that edge and compares them against a queue model it updated for that edge. Ordering is checked by draining each pool and comparing every offered tag with the model's front entry. This covers the sweep of all 32 generic tag values, the double-push and single-slot cases, and the unfiltered dedicated pushes.

// File: rtl/regfree_pools.sv
module regfree_pools #(
  parameter int INT_PHYS = 12,
  parameter int INT_ARCH = 8,
  parameter int FP_PHYS  = 10,
  parameter int FP_ARCH  = 6,
  parameter int ZERO_IDX = 0,
  localparam int TOTAL = INT_PHYS + FP_PHYS,
  localparam int TAG_W = $clog2(TOTAL),
  localparam int ICW   = $clog2(INT_PHYS + 1),
  localparam int FCW   = $clog2(FP_PHYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ia_valid,
  output logic             ia_ready,
  output logic [TAG_W-1:0] ia_tag,
  input  logic             fa_valid,
  output logic             fa_ready,
  output logic [TAG_W-1:0] fa_tag,
  input  logic             gr_valid,
  input  logic [TAG_W-1:0] gr_tag,
  input  logic             ir_valid,
  input  logic [TAG_W-1:0] ir_tag,
  input  logic             fr_valid,
  input  logic [TAG_W-1:0] fr_tag,
  output logic             int_nonempty,
  output logic [ICW-1:0]   int_count,
  output logic             fp_nonempty,
  output logic [FCW-1:0]   fp_count,
  output logic             underflow_err,
  output logic             overflow_err
);
  localparam int MAXD = (INT_PHYS > FP_PHYS) ? INT_PHYS : FP_PHYS;
  localparam int PW   = $clog2(MAXD);
  localparam int CW   = $clog2(MAXD + 1);

  logic [1:0]       pop_req, rdy, push_a, push_b, ovf;
  logic [TAG_W-1:0] data_b [2];
  logic [TAG_W-1:0] head_tag [2];
  logic [CW-1:0]    cnt [2];
  wire  [TAG_W:0]   gt = {1'b0, gr_tag};

  assign pop_req   = {fa_valid, ia_valid};
  assign push_a[0] = gr_valid && (gt < (TAG_W+1)'(INT_PHYS)) && (gt != (TAG_W+1)'(ZERO_IDX));
  assign push_a[1] = gr_valid && (gt >= (TAG_W+1)'(INT_PHYS)) && (gt < (TAG_W+1)'(TOTAL))
                     && (gt != (TAG_W+1)'(ZERO_IDX + INT_PHYS));
  assign push_b    = {fr_valid, ir_valid};
  assign data_b[0] = ir_tag;
  assign data_b[1] = fr_tag;

  for (genvar p = 0; p < 2; p++) begin : g_pool
    localparam int DEPTH = (p == 0) ? INT_PHYS : FP_PHYS;
    localparam int ARCH  = (p == 0) ? INT_ARCH : FP_ARCH;
    localparam int BASE  = (p == 0) ? 0 : INT_PHYS;
    localparam int FREE0 = DEPTH - ARCH;

    logic [TAG_W-1:0] mem [DEPTH];
    logic [PW-1:0]    head, tail, tail1, wp_b;
    logic [CW-1:0]    c;
    logic [CW:0]      room;
    logic             pop, acc_a, acc_b;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] v);
      return (int'(v) == DEPTH - 1) ? '0 : v + 1'b1;
    endfunction

    assign rdy[p]      = (c != '0);
    assign cnt[p]      = c;
    assign head_tag[p] = rdy[p] ? mem[head] : '0;
    assign pop         = pop_req[p] && rdy[p];
    assign room        = (CW+1)'(DEPTH) - {1'b0, c} + (CW+1)'(pop);
    assign acc_a       = push_a[p] && (room != '0);
    assign acc_b       = push_b[p] && (room > (CW+1)'(acc_a));
    assign ovf[p]      = (push_a[p] && !acc_a) || (push_b[p] && !acc_b);
    assign tail1       = nxt(tail);
    assign wp_b        = acc_a ? tail1 : tail;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head <= '0;
        tail <= PW'(FREE0 % DEPTH);
        c    <= CW'(FREE0);
      end else begin
        if (pop) head <= nxt(head);
        if (acc_a || acc_b) tail <= (acc_a && acc_b) ? nxt(tail1) : tail1;
        c <= c - CW'(pop) + CW'(acc_a) + CW'(acc_b);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++)
          mem[i] <= (i < FREE0) ? TAG_W'(BASE + ARCH + i) : '0;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (acc_a && int'(tail) == i) mem[i] <= gr_tag;
          if (acc_b && int'(wp_b) == i) mem[i] <= data_b[p];
        end
      end
    end
  end

  assign ia_ready     = rdy[0];
  assign ia_tag       = head_tag[0];
  assign int_nonempty = rdy[0];
  assign int_count    = ICW'(cnt[0]);
  assign fa_ready     = rdy[1];
  assign fa_tag       = head_tag[1];
  assign fp_nonempty  = rdy[1];
  assign fp_count     = FCW'(cnt[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underflow_err <= 1'b0;
      overflow_err  <= 1'b0;
    end else begin
      underflow_err <= underflow_err | (ia_valid & ~rdy[0]) | (fa_valid & ~rdy[1]);
      overflow_err  <= overflow_err | (|ovf);
    end
  end
endmodule

// File: rtl/regfree_pools_chk.sv
module regfree_pools_chk #(
  parameter int INT_PHYS = 12,
  parameter int FP_PHYS  = 10,
  localparam int TOTAL = INT_PHYS + FP_PHYS,
  localparam int TAG_W = $clog2(TOTAL),
  localparam int ICW   = $clog2(INT_PHYS + 1),
  localparam int FCW   = $clog2(FP_PHYS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ia_valid,
  input logic             ia_ready,
  input logic [TAG_W-1:0] ia_tag,
  input logic             fa_valid,
  input logic             fa_ready,
  input logic             gr_valid,
  input logic [TAG_W-1:0] gr_tag,
  input logic             ir_valid,
  input logic             fr_valid,
  input logic             int_nonempty,
  input logic [ICW-1:0]   int_count,
  input logic [FCW-1:0]   fp_count,
  input logic             underflow_err,
  input logic             overflow_err
);
  p_ready_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ia_ready == (int_count != '0)) && (int_nonempty == ia_ready));
  p_empty_no_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ia_ready |-> ia_tag == '0);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(int_count) <= INT_PHYS && int'(fp_count) <= FP_PHYS);
  p_pop_decrements_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ia_valid && ia_ready && !gr_valid && !ir_valid |=> int_count == $past(int_count) - 1'b1);
  p_underflow_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ia_valid && !ia_ready) || (fa_valid && !fa_ready) |=> underflow_err);
  p_underflow_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);
  p_range_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gr_valid && int'(gr_tag) >= TOTAL && !ir_valid && !fr_valid && !ia_valid && !fa_valid
    |=> $stable(int_count) && $stable(fp_count));
  p_swap_keeps_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ia_valid && ia_ready && ir_valid && !gr_valid |=> $stable(int_count));
  p_overflow_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);
endmodule

bind regfree_pools regfree_pools_chk #(.INT_PHYS(INT_PHYS), .FP_PHYS(FP_PHYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ia_valid(ia_valid), .ia_ready(ia_ready), .ia_tag(ia_tag),
  .fa_valid(fa_valid), .fa_ready(fa_ready), .gr_valid(gr_valid), .gr_tag(gr_tag),
  .ir_valid(ir_valid), .fr_valid(fr_valid), .int_nonempty(int_nonempty),
  .int_count(int_count), .fp_count(fp_count), .underflow_err(underflow_err),
  .overflow_err(overflow_err));

// File: tb/test_regfree_pools.sv
`timescale 1ns/1ps
module test_regfree_pools;
  localparam int IP = 12, IA = 8, FPP = 10, FA = 6, Z = 0;
  localparam int TOT = IP + FPP;

  logic clk = 0, rst_n = 0;
  logic ia_valid = 0, fa_valid = 0, gr_valid = 0, ir_valid = 0, fr_valid = 0;
  logic [4:0] gr_tag = 0, ir_tag = 0, fr_tag = 0;
  logic ia_ready, fa_ready, int_nonempty, fp_nonempty, underflow_err, overflow_err;
  logic [4:0] ia_tag, fa_tag;
  logic [3:0] int_count, fp_count;

  int iq[$], fq[$];
  int errs = 0, checks = 0;
  bit exp_unf = 0, exp_ovf = 0;

  always #5 clk = ~clk;

  regfree_pools #(.INT_PHYS(IP), .INT_ARCH(IA), .FP_PHYS(FPP), .FP_ARCH(FA), .ZERO_IDX(Z))
  i_regfree_pools (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(req, "int_count", int'(int_count), iq.size());
    chk(req, "fp_count", int'(fp_count), fq.size());
    chk(req, "int_nonempty", int'(int_nonempty), int'(iq.size() > 0));
    chk(req, "fp_nonempty", int'(fp_nonempty), int'(fq.size() > 0));
    chk(req, "underflow_err", int'(underflow_err), int'(exp_unf));
    chk(req, "overflow_err", int'(overflow_err), int'(exp_ovf));
  endtask

  task automatic mpush(ref int q[$], input int depth, input int tag);
    if (q.size() < depth) q.push_back(tag);
    else exp_ovf = 1;
  endtask

  task automatic step(bit ia, bit fa, bit gv, int gt, bit iv, int it, bit fv, int ft, string req);
    @(negedge clk);
    ia_valid = ia; fa_valid = fa; gr_valid = gv; gr_tag = 5'(gt);
    ir_valid = iv; ir_tag = 5'(it); fr_valid = fv; fr_tag = 5'(ft);
    #1;
    chk(req, "ia_ready", int'(ia_ready), int'(iq.size() > 0));
    chk(req, "ia_tag", int'(ia_tag), iq.size() > 0 ? iq[0] : 0);
    chk(req, "fa_ready", int'(fa_ready), int'(fq.size() > 0));
    chk(req, "fa_tag", int'(fa_tag), fq.size() > 0 ? fq[0] : 0);
    @(posedge clk);
    if (ia) begin if (iq.size() > 0) void'(iq.pop_front()); else exp_unf = 1; end
    if (fa) begin if (fq.size() > 0) void'(fq.pop_front()); else exp_unf = 1; end
    if (gv) begin
      if (gt < IP) begin if (gt != Z) mpush(iq, IP, gt); end
      else if (gt < TOT) begin if (gt != Z + IP) mpush(fq, FPP, gt); end
    end
    if (iv) mpush(iq, IP, it);
    if (fv) mpush(fq, FPP, ft);
    #1;
    ia_valid = 0; fa_valid = 0; gr_valid = 0; ir_valid = 0; fr_valid = 0;
    check_state(req);
  endtask

  task automatic drain(string req);
    while (iq.size() > 0 || fq.size() > 0)
      step(iq.size() > 0, fq.size() > 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = IA; i < IP; i++) iq.push_back(i);
    for (int i = IP + FA; i < TOT; i++) fq.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check_state("R1");
    // R1 R2: initial contents come out ascending
    drain("R1");
    // R4: allocate from empty pools
    step(1, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R4");
    // R5 R6 R7: every generic tag value
    for (int t = 0; t < 32; t++)
      step(0, 0, 1, t, 0, 0, 0, 0, (t == Z || t == Z + IP) ? "R6" : (t >= TOT ? "R7" : "R5"));
    drain("R2");
    // R8: dedicated ports are unfiltered
    step(0, 0, 0, 0, 1, 0, 1, 12, "R8");
    step(0, 0, 0, 0, 1, 30, 1, 3, "R8");
    drain("R8");
    // R10: generic ahead of dedicated
    step(0, 0, 1, 5, 1, 7, 0, 0, "R10");
    step(0, 0, 1, 15, 0, 0, 1, 17, "R10");
    step(0, 0, 1, 2, 1, 9, 1, 20, "R10");
    drain("R10");
    // R9: pop and push in one cycle
    for (int k = 1; k <= 3; k++) step(0, 0, 0, 0, 1, k, 1, IP + k, "R9");
    step(1, 0, 1, 9, 0, 0, 0, 0, "R9");
    step(1, 1, 0, 0, 1, 4, 1, 19, "R9");
    drain("R9");
    // R11: overflow and the last-slot rule
    for (int k = 1; k <= 11; k++) step(0, 0, 0, 0, 1, k, 0, 0, "R11");
    step(0, 0, 1, 4, 1, 6, 0, 0, "R11");
    step(0, 0, 0, 0, 1, 8, 0, 0, "R11");
    step(1, 0, 0, 0, 1, 10, 0, 0, "R11");
    drain("R11");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule